// File: doc/BRIEF.md
# CAN Error and Status Register Bank

This block is the register bank that reports the error and status picture of a CAN controller to a CPU. A protocol engine feeds it single-cycle event pulses for the six bit-level error kinds, and separate pulses for bus-off and wakeup. It also feeds in its current transmit and receive error counter values and its live line state: idle, transmitting/receiving and the 2-bit fault confinement state. The block does not compute the counters. It only observes them.

Error events are latched as sticky bits until software reads the status word, and that read clears them. Two warning bits follow the error counters against a threshold of 96. Five interrupt flags are cleared by writing 1: transmit warning, receive warning, bus-off, error and wakeup. Each flag is gated by its own mask bit, and the gated flags drive one interrupt line. A warning interrupt flag sets only when its counter first crosses the threshold, and only while a global warning enable is on. The CPU port is a plain strobe interface: read data is combinational from `addr_i`, and a read or write takes effect on the clock edge where `rd_i` or `wr_i` is high.

The word map has three addresses. Address 0 is the control word: bit 0 is the warning enable, and bits 1 to 5 are the masks for transmit warning, receive warning, bus-off, error and wakeup. Address 1 is the counter word. Address 2 is the status word. Address 3 reads 0.

Top module: `can_err_status`

## Requirements
- R1: After reset, with all inputs at 0, the control, counter and status words read 0 and `irq_o` is 0.
- R2: An error pulse sets its status bit, and the bit stays set until a read of the status word. The bits are stuff 10, form 11, crc 12, ack 13, bit0 14 and bit1 15, taken from `err_ev_i` bits 0 to 5. That read returns the bits and clears status bits 15:8. Pulses in separate cycles accumulate.
- R3: If an error pulse arrives in the same cycle as a clearing status read, its bit is still set after the read.
- R4: Status bit 9 (transmit warning) sets when `tx_cnt_i` is 96 or more. Status bit 8 (receive warning) does the same for `rx_cnt_i`. A count of 95 does not set either bit.
- R5: The transmit warning flag (status bit 17) and the receive warning flag (status bit 16) set only when their counter rises from below 96 to 96 or more while control bit 0 is 1. A counter that is already at or above 96 when the enable turns on sets nothing.
- R6: Writing 1 to status bit 17, 16, 2, 1 or 0 clears that flag. Writing 0 leaves it unchanged.
- R7: Any error pulse sets the error flag (status bit 1). A bus-off pulse sets status bit 2. A wakeup pulse sets status bit 0.
- R8: `irq_o` is high while any flag is set with its mask bit set, and stays high until software clears the flag or the mask.
- R9: The counter word reads `tx_cnt_i` in bits 7:0 and `rx_cnt_i` in bits 15:8, with bits 31:16 at 0. Writes to it have no effect.
- R10: The status word shows `flt_conf_i` in bits 5:4, `txrx_i` in bit 6 and `idle_i` in bit 7. Bit 3 and bits 31:18 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_ev_i | input | 6 | Error pulses: stuff, form, crc, ack, bit0, bit1 (bits 0..5) |
| boff_ev_i | input | 1 | Bus-off entry pulse |
| wake_ev_i | input | 1 | Wakeup pulse |
| tx_cnt_i | input | 8 | Transmit error counter |
| rx_cnt_i | input | 8 | Receive error counter |
| idle_i | input | 1 | Bus idle status |
| txrx_i | input | 1 | Transmitting/receiving status |
| flt_conf_i | input | 2 | Fault confinement state |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The error capture path is driven from a vector table. Some entries are single pulses, which tell the six bit positions apart. Other entries are two pulses in separate cycles, which show that captured bits accumulate rather than overwrite each other. A second read after each one shows that the clear-on-read really clears.

The warning path uses counts of 95, 96 and 100. It turns the warning enable on before and after the crossing, which separates a level detector from an edge detector.

Further directed sequences cover three cases:
- an event that coincides with a read;
- write-0 and write-1 on the flags;
- each mask in turn, which shows that the interrupt follows only enabled pairs.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int N_ERR  = 6;
  localparam int N_FLAG = 5;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_STAT = 2'd2
  } esr_addr_e;

  // flag vector order
  localparam int F_WAK  = 0;
  localparam int F_ERR  = 1;
  localparam int F_BOFF = 2;
  localparam int F_RWRN = 3;
  localparam int F_TWRN = 4;
endpackage

// File: rtl/can_esr_warn.sv
module can_esr_warn #(
  parameter int CNT_W = 8,
  parameter int LVL   = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_clr_i,
  output logic             wrn_o,
  output logic             rise_o
);
  logic lvl, lvl_q;

  assign lvl    = cnt_i >= CNT_W'(LVL);
  assign rise_o = lvl & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      wrn_o <= 1'b0;
    end else begin
      lvl_q <= lvl;
      wrn_o <= lvl | (wrn_o & ~rd_clr_i);
    end
  end

  AST_RISE_SETS_WRN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> wrn_o); // R4
endmodule

// File: rtl/can_esr_errcap.sv
module can_esr_errcap #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] err_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_o[i] <= 1'b0;
      else         err_o[i] <= ev_i[i] | (err_o[i] & ~rd_clr_i);
    end

    AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o[i] && !rd_clr_i) |=> err_o[i]); // R2
    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> err_o[i]); // R3
  end
endmodule

// File: rtl/can_esr_intflags.sv
module can_esr_intflags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // set takes priority over a same-cycle clear
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[i] <= 1'b0;
      else         flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
    end

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]); // R6
  end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_esr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LVL = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ERR-1:0]  err_ev_i,
  input  logic              boff_ev_i,
  input  logic              wake_ev_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              idle_i,
  input  logic              txrx_i,
  input  logic [1:0]        flt_conf_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CTRL_W = 1 + N_FLAG;

  logic [CTRL_W-1:0] ctrl_q;
  logic              stat_rd, stat_wr, ctrl_wr;
  logic [N_ERR-1:0]  err_q;
  logic              tx_wrn, rx_wrn, tx_rise, rx_rise;
  logic [N_FLAG-1:0] flag_set, flag_clr, flags, masks;
  logic [DATA_W-1:0] stat_word, cnt_word, ctrl_word;
  logic              unused_wdata;

  assign stat_rd = rd_i && (addr_i == ADDR_STAT);
  assign stat_wr = wr_i && (addr_i == ADDR_STAT);
  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  can_esr_errcap #(.N(N_ERR)) u_errcap (
    .clk_i, .rst_ni, .ev_i(err_ev_i), .rd_clr_i(stat_rd), .err_o(err_q)
  );

  can_esr_warn #(.CNT_W(CNT_W), .LVL(WARN_LVL)) u_tx_warn (
    .clk_i, .rst_ni, .cnt_i(tx_cnt_i), .rd_clr_i(stat_rd),
    .wrn_o(tx_wrn), .rise_o(tx_rise)
  );

  can_esr_warn #(.CNT_W(CNT_W), .LVL(WARN_LVL)) u_rx_warn (
    .clk_i, .rst_ni, .cnt_i(rx_cnt_i), .rd_clr_i(stat_rd),
    .wrn_o(rx_wrn), .rise_o(rx_rise)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_WAK]  = wake_ev_i;
    flag_set[F_ERR]  = |err_ev_i;
    flag_set[F_BOFF] = boff_ev_i;
    flag_set[F_RWRN] = rx_rise & ctrl_q[0];
    flag_set[F_TWRN] = tx_rise & ctrl_q[0];

    flag_clr         = '0;
    flag_clr[F_WAK]  = stat_wr & wdata_i[0];
    flag_clr[F_ERR]  = stat_wr & wdata_i[1];
    flag_clr[F_BOFF] = stat_wr & wdata_i[2];
    flag_clr[F_RWRN] = stat_wr & wdata_i[16];
    flag_clr[F_TWRN] = stat_wr & wdata_i[17];

    masks         = '0;
    masks[F_TWRN] = ctrl_q[1];
    masks[F_RWRN] = ctrl_q[2];
    masks[F_BOFF] = ctrl_q[3];
    masks[F_ERR]  = ctrl_q[4];
    masks[F_WAK]  = ctrl_q[5];
  end

  can_esr_intflags #(.N(N_FLAG)) u_flags (
    .clk_i, .rst_ni, .set_i(flag_set), .clr_i(flag_clr), .flag_o(flags)
  );

  assign irq_o = |(flags & masks);

  always_comb begin
    stat_word       = '0;
    stat_word[0]    = flags[F_WAK];
    stat_word[1]    = flags[F_ERR];
    stat_word[2]    = flags[F_BOFF];
    stat_word[5:4]  = flt_conf_i;
    stat_word[6]    = txrx_i;
    stat_word[7]    = idle_i;
    stat_word[8]    = rx_wrn;
    stat_word[9]    = tx_wrn;
    stat_word[15:10] = err_q;
    stat_word[16]   = flags[F_RWRN];
    stat_word[17]   = flags[F_TWRN];

    cnt_word = '0;
    cnt_word[CNT_W-1:0]       = tx_cnt_i;
    cnt_word[2*CNT_W-1:CNT_W] = rx_cnt_i;

    ctrl_word = '0;
    ctrl_word[CTRL_W-1:0] = ctrl_q;

    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_word;
      ADDR_CNT:  rdata_o = cnt_word;
      ADDR_STAT: rdata_o = stat_word;
      default:   rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^{wdata_i[DATA_W-1:18], wdata_i[15:CTRL_W]};

  AST_TWRN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_TWRN]) |-> ($past(ctrl_q[0]) && $past(tx_cnt_i) >= CNT_W'(WARN_LVL))); // R5
  AST_RWRN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_RWRN]) |-> ($past(ctrl_q[0]) && $past(rx_cnt_i) >= CNT_W'(WARN_LVL))); // R5
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_wr && !ctrl_wr) |=> irq_o); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> (rdata_o[31:18] == '0 && !rdata_o[3])); // R10
endmodule

// File: tb/can_err_status_tb.sv
module can_err_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  err_ev = '0;
  logic        boff_ev = 1'b0, wake_ev = 1'b0;
  logic [7:0]  tx_cnt = '0, rx_cnt = '0;
  logic        idle = 1'b0, txrx = 1'b0;
  logic [1:0]  flt = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] d;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_STAT = 2'd2;

  // {first pulse, second pulse}
  localparam logic [11:0] VEC [6] = '{
    {6'b000001, 6'b000000}, {6'b000010, 6'b000000}, {6'b000100, 6'b001000},
    {6'b010000, 6'b000000}, {6'b100000, 6'b000001}, {6'b101010, 6'b010101}
  };

  always #4 clk = ~clk;

  can_err_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_ev_i(err_ev), .boff_ev_i(boff_ev),
    .wake_ev_i(wake_ev), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .idle_i(idle),
    .txrx_i(txrx), .flt_conf_i(flt), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wr_word(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_err(input logic [5:0] e);
    @(negedge clk); err_ev = e;
    @(posedge clk); #1 err_ev = '0;
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20 rst_n = 1'b1;
    idle_cyc(2);

    // R1 reset state
    rd_word(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd_word(A_CNT, d);  check("R1 cnt", d, 32'h0);
    rd_word(A_STAT, d); check("R1 stat", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R9 counter word
    tx_cnt = 8'h5A; rx_cnt = 8'hC3;
    rd_word(A_CNT, d); check("R9 cnt", d, 32'h0000C35A);
    wr_word(A_CNT, 32'hFFFF_FFFF);
    rd_word(A_CNT, d); check("R9 cnt write ignored", d, 32'h0000C35A);
    tx_cnt = '0; rx_cnt = '0;

    // R10 live fields and reserved bits
    flt = 2'b10; txrx = 1'b1; idle = 1'b1;
    rd_word(A_STAT, d); check("R10 live fields", d & 32'hF8, 32'hE0);
    wr_word(A_STAT, 32'hFFFC_0008);
    rd_word(A_STAT, d); check("R10 reserved", d & 32'hFFFC_0008, 32'h0);
    flt = '0; txrx = 1'b0; idle = 1'b0;

    // R2 / R7 vector table
    for (int i = 0; i < 6; i++) begin
      pulse_err(VEC[i][11:6]);
      pulse_err(VEC[i][5:0]);
      rd_word(A_STAT, d);
      check("R2 capture", {26'h0, d[15:10]}, {26'h0, VEC[i][11:6] | VEC[i][5:0]});
      check("R7 err flag", {31'h0, d[1]}, 32'h1);
      rd_word(A_STAT, d);
      check("R2 cleared by read", {24'h0, d[15:8]}, 32'h0);
    end

    // R6 write 0 keeps, write 1 clears
    wr_word(A_STAT, 32'h0);
    rd_word(A_STAT, d); check("R6 write0 keeps", {31'h0, d[1]}, 32'h1);
    wr_word(A_STAT, 32'h2);
    rd_word(A_STAT, d); check("R6 write1 clears", {31'h0, d[1]}, 32'h0);

    // R7 bus-off and wakeup
    @(negedge clk); boff_ev = 1'b1; @(posedge clk); #1 boff_ev = 1'b0;
    @(negedge clk); wake_ev = 1'b1; @(posedge clk); #1 wake_ev = 1'b0;
    rd_word(A_STAT, d); check("R7 boff wak", {29'h0, d[2:0]}, 32'h5);
    wr_word(A_STAT, 32'h5);
    rd_word(A_STAT, d); check("R6 clear boff wak", {29'h0, d[2:0]}, 32'h0);

    // R3 event in the read cycle
    @(negedge clk); addr = A_STAT; rd = 1'b1; err_ev = 6'b000100;
    @(posedge clk); #1 rd = 1'b0; err_ev = '0;
    rd_word(A_STAT, d); check("R3 event wins", {31'h0, d[12]}, 32'h1);
    rd_word(A_STAT, d); check("R3 then clears", {31'h0, d[12]}, 32'h0);
    wr_word(A_STAT, 32'h2);

    // R4 / R5 warning thresholds
    tx_cnt = 8'd95; idle_cyc(2);
    rd_word(A_STAT, d); check("R4 tx 95", {31'h0, d[9]}, 32'h0);
    tx_cnt = 8'd96; idle_cyc(2);
    rd_word(A_STAT, d); check("R4 tx 96", {31'h0, d[9]}, 32'h1);
    check("R5 no enable", {31'h0, d[17]}, 32'h0);
    wr_word(A_CTRL, 32'h1); idle_cyc(2);
    rd_word(A_STAT, d); check("R5 no edge", {31'h0, d[17]}, 32'h0);
    tx_cnt = 8'd0; idle_cyc(2);
    tx_cnt = 8'd100; idle_cyc(2);
    rd_word(A_STAT, d); check("R5 tx edge", {31'h0, d[17]}, 32'h1);
    rx_cnt = 8'd96; idle_cyc(2);
    rd_word(A_STAT, d);
    check("R4 rx 96", {31'h0, d[8]}, 32'h1);
    check("R5 rx edge", {31'h0, d[16]}, 32'h1);

    // R8 masking
    check("R8 masked", {31'h0, irq}, 32'h0);
    wr_word(A_CTRL, 32'h3);
    check("R8 twrn mask", {31'h0, irq}, 32'h1);
    wr_word(A_STAT, 32'h0002_0000);
    check("R8 drop after clear", {31'h0, irq}, 32'h0);
    wr_word(A_CTRL, 32'h5);
    check("R8 rwrn mask", {31'h0, irq}, 32'h1);
    idle_cyc(3);
    check("R8 held", {31'h0, irq}, 32'h1);
    wr_word(A_STAT, 32'h0001_0000);
    check("R8 rwrn cleared", {31'h0, irq}, 32'h0);
    wr_word(A_CTRL, 32'h11);
    pulse_err(6'b001000);
    check("R8 err mask", {31'h0, irq}, 32'h1);
    wr_word(A_STAT, 32'h2);
    check("R8 err cleared", {31'h0, irq}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule